// File: doc/BRIEF.md
# Floating-Point Instruction Decoder

This block turns a 32-bit floating-point instruction word into the control a pipeline needs: an operation code, an operand-form class, the raw register and control fields, a record-bit flag and an illegal-instruction flag. It covers memory transfers with a displacement or with an index register, the single- and double-precision arithmetic group (including fused multiply-add and select), and the register-form group of compare, conversion, move and status-register operations.

The decode itself is purely combinational. A single output register stage follows it, so the decoder can sit in a pipeline slot. A word presented with `in_valid` high is captured at the next rising clock edge. While `in_valid` is low the captured result is held. The operation and form codes are the enumerated values `fop_e` and `form_e` of the package `fpdec_pkg`. In both enumerations the value 0 means "none", which is `OP_NOP` and `FM_NONE`.

Top module: `fpdec_top`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, `out_valid` is 0 after that edge. The captured decode resets to `OP_NOP`/`FM_NONE`, not illegal.
- R2: `out_valid` equals the `in_valid` sampled at the previous edge. When `in_valid` is low, every data output keeps its value.
- R3: Primary opcode (bits 31:26) values 48..55 decode in turn to `OP_LDS`, `OP_LDSU`, `OP_LDD`, `OP_LDDU`, `OP_STS`, `OP_STSU`, `OP_STD` and `OP_STDU`. The update forms (odd values) take the form class `FM_DISPU`; the others take `FM_DISP`.
- R4: An update displacement form (primary opcode 49, 51, 53 or 55) whose A field (bits 20:16) is zero is illegal.
- R5: Primary opcode 31 decodes the 10-bit field at bits 10:1. The values 535/567/599/631/663/695/727/759 give `OP_LDSX`/`OP_LDSUX`/`OP_LDDX`/`OP_LDDUX`/`OP_STSX`/`OP_STSUX`/`OP_STDX`/`OP_STDUX`, and 983 gives `OP_STIW`. Non-update forms take `FM_IDX` and update forms take `FM_IDXU`. Any other value is illegal.
- R6: Under primary opcode 31, a non-update indexed form with a zero A field is illegal, except `OP_STIW`. The update indexed forms accept a zero A field.
- R7: Primary opcode 59 decodes bits 5:1 as follows. 18 gives DIVS, 20 SUBS, 21 ADDS, 22 SQRTS, 24 RECS, 25 MULS, 28 MSUBS, 29 MADDS, 30 NMSUBS and 31 NMADDS. Every other value, including 23 and 26, is illegal.
- R8: Primary opcode 63 with bit 5 set decodes bits 5:1 as the double-precision set: DIV, SUB, ADD, SQRT, MUL, MSUB, MADD, NMSUB and NMADD on the same values as R7, plus 23 `OP_SEL` and 26 `OP_RSQE`. The value 24 is illegal.
- R9: Primary opcode 63 with bit 5 clear decodes bits 10:1 as follows. 0 gives CMPU, 12 RND, 14 CVT, 15 CVTZ, 32 CMPO, 38 SETB, 40 NEG, 64 STCR, 70 CLRB, 72 MOV, 134 SETFI, 136 NABS, 264 ABS, 583 RDST and 711 WRST. Other values are illegal.
- R10: Every legal result carries a form class other than `FM_NONE`. Multiply takes `FM_AC` (second source in the C field). Select and the fused forms take `FM_ABC`. The other arithmetic takes `FM_AB`. Compares take `FM_CMP`, status-bit set/clear takes `FM_BIT`, and the move of a status field to the condition register takes `FM_CRMOV`. The immediate field set takes `FM_IMM`, the mask write takes `FM_MASK` and the status read takes `FM_T`. The remaining register-form operations take `FM_TB`.
- R11: `out_rt`, `out_ra`, `out_rb` and `out_rc` are bits 25:21, 20:16, 15:11 and 10:6 of the captured word.
- R12: `out_crf` is bits 25:23, `out_crs` is bits 20:18, `out_imm` is bits 15:12 and `out_mask` is bits 24:17 of the captured word.
- R13: `out_rec` is bit 0 of the captured word.
- R14: Any primary opcode other than 31, 48..55, 59 and 63 is illegal. An illegal word yields `OP_NOP` and `FM_NONE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Word on `insn` is to be captured |
| insn | input | 32 | Instruction word |
| out_valid | output | 1 | Captured decode presented this cycle |
| out_illegal | output | 1 | Captured word is not a recognised instruction |
| out_rec | output | 1 | Record bit of captured word |
| out_op | output | 6 | Operation code (`fop_e`) |
| out_form | output | 4 | Operand-form class (`form_e`) |
| out_rt | output | 5 | Target register field |
| out_ra | output | 5 | A register field |
| out_rb | output | 5 | B register field |
| out_rc | output | 5 | C register field |
| out_crf | output | 3 | Condition-register field number |
| out_crs | output | 3 | Source status field number |
| out_imm | output | 4 | Status-field immediate |
| out_mask | output | 8 | Status-field write mask |

## Verification
The bound checker watches the pipeline-stage behaviour on every cycle:
- reset clearing the valid output;
- `out_valid` tracking `in_valid` one edge later;
- all outputs holding while `in_valid` is low;
- the record bit and target field passing through;
- unknown primary opcodes turning into a no-op;
- every legal result carrying a form class.

Only the directed scenarios can show the full opcode-to-operation mapping. That mapping covers:
- the split of primary opcode 63 on bit 5;
- the values that are legal under one arithmetic primary opcode but not the other;
- the zero-A-field rules of the update and indexed forms;
- the placement of the control fields.

// File: rtl/fpdec_pkg.sv
// fpdec_pkg: shared widths, primary opcode values, operation and form
// enumerations for the floating-point instruction decoder.
// Assumes a 32-bit instruction word with the primary opcode in the top bits.
package fpdec_pkg;
    localparam int INSN_W = 32;
    localparam int PRIM_W = 6;
    localparam int XO_W   = 10;
    localparam int AO_W   = 5;
    localparam int REG_W  = 5;
    localparam int CRF_W  = 3;
    localparam int IMM_W  = 4;
    localparam int MASK_W = 8;
    localparam int OP_W   = 6;
    localparam int FORM_W = 4;

    localparam logic [PRIM_W-1:0] PRI_IDX  = 6'd31;
    localparam logic [PRIM_W-1:0] PRI_SGL  = 6'd59;
    localparam logic [PRIM_W-1:0] PRI_DBL  = 6'd63;
    localparam logic [PRIM_W-1:0] PRI_MEM0 = 6'd48;
    localparam logic [PRIM_W-1:0] PRI_MEM7 = 6'd55;

    typedef enum logic [OP_W-1:0] {
        OP_NOP,
        OP_LDS, OP_LDSU, OP_LDD, OP_LDDU, OP_STS, OP_STSU, OP_STD, OP_STDU,
        OP_LDSX, OP_LDSUX, OP_LDDX, OP_LDDUX, OP_STSX, OP_STSUX, OP_STDX,
        OP_STDUX, OP_STIW,
        OP_DIVS, OP_SUBS, OP_ADDS, OP_SQRTS, OP_RECS, OP_MULS, OP_MSUBS,
        OP_MADDS, OP_NMSUBS, OP_NMADDS,
        OP_DIV, OP_SUB, OP_ADD, OP_SQRT, OP_SEL, OP_MUL, OP_RSQE, OP_MSUB,
        OP_MADD, OP_NMSUB, OP_NMADD,
        OP_CMPU, OP_RND, OP_CVT, OP_CVTZ, OP_CMPO, OP_SETB, OP_NEG, OP_STCR,
        OP_CLRB, OP_MOV, OP_SETFI, OP_NABS, OP_ABS, OP_RDST, OP_WRST
    } fop_e;

    typedef enum logic [FORM_W-1:0] {
        FM_NONE, FM_AB, FM_AC, FM_ABC, FM_DISP, FM_DISPU, FM_IDX, FM_IDXU,
        FM_T, FM_TB, FM_CMP, FM_CRMOV, FM_BIT, FM_IMM, FM_MASK
    } form_e;

    typedef struct packed {
        logic  hit;
        fop_e  op;
        form_e form;
    } dec_t;

    localparam dec_t DEC_MISS = '{hit: 1'b0, op: OP_NOP, form: FM_NONE};
endpackage

// File: rtl/fpdec_mem.sv
// fpdec_mem: decodes the memory-transfer group, i.e. the displacement forms
// (primary opcodes 48..55) and the indexed forms under primary opcode 31.
// Assumes the caller only uses the result for those primary opcodes.
module fpdec_mem
    import fpdec_pkg::*;
(
    input  logic [PRIM_W-1:0] prim,
    input  logic [REG_W-1:0]  ra,
    input  logic [XO_W-1:0]   xo,
    output dec_t              res
);
    logic a_zero;

    // Flags a zero base-register field, which restricts some forms.
    always_comb a_zero = (ra == '0);

    // Maps primary and extended opcode values to operation and form.
    always_comb begin
        res = DEC_MISS;
        case (prim)
            6'd48: res = '{1'b1,    OP_LDS,  FM_DISP};
            6'd49: res = '{!a_zero, OP_LDSU, FM_DISPU};
            6'd50: res = '{1'b1,    OP_LDD,  FM_DISP};
            6'd51: res = '{!a_zero, OP_LDDU, FM_DISPU};
            6'd52: res = '{1'b1,    OP_STS,  FM_DISP};
            6'd53: res = '{!a_zero, OP_STSU, FM_DISPU};
            6'd54: res = '{1'b1,    OP_STD,  FM_DISP};
            6'd55: res = '{!a_zero, OP_STDU, FM_DISPU};
            PRI_IDX: begin
                case (xo)
                    10'd535: res = '{!a_zero, OP_LDSX,  FM_IDX};
                    10'd567: res = '{1'b1,    OP_LDSUX, FM_IDXU};
                    10'd599: res = '{!a_zero, OP_LDDX,  FM_IDX};
                    10'd631: res = '{1'b1,    OP_LDDUX, FM_IDXU};
                    10'd663: res = '{!a_zero, OP_STSX,  FM_IDX};
                    10'd695: res = '{1'b1,    OP_STSUX, FM_IDXU};
                    10'd727: res = '{!a_zero, OP_STDX,  FM_IDX};
                    10'd759: res = '{1'b1,    OP_STDUX, FM_IDXU};
                    10'd983: res = '{1'b1,    OP_STIW,  FM_IDX};
                    default: res = DEC_MISS;
                endcase
            end
            default: res = DEC_MISS;
        endcase
    end
endmodule

// File: rtl/fpdec_arith.sv
// fpdec_arith: decodes the 5-bit arithmetic field (bits 5:1).
// DOUBLE selects the double-precision set (adds select and reciprocal
// square-root estimate, drops reciprocal estimate), else the single set.
// Assumes the caller applies it only to the matching primary opcode.
module fpdec_arith
    import fpdec_pkg::*;
#(
    parameter bit DOUBLE = 1'b0
)(
    input  logic [AO_W-1:0] ao,
    output dec_t            res
);
    generate
        if (DOUBLE) begin : g_dbl
            // Double-precision arithmetic table.
            always_comb begin
                case (ao)
                    5'd18:   res = '{1'b1, OP_DIV,   FM_AB};
                    5'd20:   res = '{1'b1, OP_SUB,   FM_AB};
                    5'd21:   res = '{1'b1, OP_ADD,   FM_AB};
                    5'd22:   res = '{1'b1, OP_SQRT,  FM_AB};
                    5'd23:   res = '{1'b1, OP_SEL,   FM_ABC};
                    5'd25:   res = '{1'b1, OP_MUL,   FM_AC};
                    5'd26:   res = '{1'b1, OP_RSQE,  FM_AB};
                    5'd28:   res = '{1'b1, OP_MSUB,  FM_ABC};
                    5'd29:   res = '{1'b1, OP_MADD,  FM_ABC};
                    5'd30:   res = '{1'b1, OP_NMSUB, FM_ABC};
                    5'd31:   res = '{1'b1, OP_NMADD, FM_ABC};
                    default: res = DEC_MISS;
                endcase
            end
        end else begin : g_sgl
            // Single-precision arithmetic table.
            always_comb begin
                case (ao)
                    5'd18:   res = '{1'b1, OP_DIVS,   FM_AB};
                    5'd20:   res = '{1'b1, OP_SUBS,   FM_AB};
                    5'd21:   res = '{1'b1, OP_ADDS,   FM_AB};
                    5'd22:   res = '{1'b1, OP_SQRTS,  FM_AB};
                    5'd24:   res = '{1'b1, OP_RECS,   FM_AB};
                    5'd25:   res = '{1'b1, OP_MULS,   FM_AC};
                    5'd28:   res = '{1'b1, OP_MSUBS,  FM_ABC};
                    5'd29:   res = '{1'b1, OP_MADDS,  FM_ABC};
                    5'd30:   res = '{1'b1, OP_NMSUBS, FM_ABC};
                    5'd31:   res = '{1'b1, OP_NMADDS, FM_ABC};
                    default: res = DEC_MISS;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/fpdec_misc.sv
// fpdec_misc: decodes the 10-bit register-form field (bits 10:1) used by
// compare, convert, move and status-register operations.
// Assumes the caller applies it only when bit 5 of the word is clear.
module fpdec_misc
    import fpdec_pkg::*;
(
    input  logic [XO_W-1:0] xo,
    output dec_t            res
);
    // Register-form operation table.
    always_comb begin
        case (xo)
            10'd0:   res = '{1'b1, OP_CMPU,  FM_CMP};
            10'd12:  res = '{1'b1, OP_RND,   FM_TB};
            10'd14:  res = '{1'b1, OP_CVT,   FM_TB};
            10'd15:  res = '{1'b1, OP_CVTZ,  FM_TB};
            10'd32:  res = '{1'b1, OP_CMPO,  FM_CMP};
            10'd38:  res = '{1'b1, OP_SETB,  FM_BIT};
            10'd40:  res = '{1'b1, OP_NEG,   FM_TB};
            10'd64:  res = '{1'b1, OP_STCR,  FM_CRMOV};
            10'd70:  res = '{1'b1, OP_CLRB,  FM_BIT};
            10'd72:  res = '{1'b1, OP_MOV,   FM_TB};
            10'd134: res = '{1'b1, OP_SETFI, FM_IMM};
            10'd136: res = '{1'b1, OP_NABS,  FM_TB};
            10'd264: res = '{1'b1, OP_ABS,   FM_TB};
            10'd583: res = '{1'b1, OP_RDST,  FM_T};
            10'd711: res = '{1'b1, OP_WRST,  FM_MASK};
            default: res = DEC_MISS;
        endcase
    end
endmodule

// File: rtl/fpdec_top.sv
// fpdec_top: floating-point instruction decoder with one output register.
// Routes the word to the sub-decoder chosen by the primary opcode (and by
// bit 5 for primary opcode 63), forces a no-op on illegal words, and
// captures the result plus raw fields when in_valid is high.
// Assumes a synchronous active-low reset.
module fpdec_top
    import fpdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] insn,
    output logic              out_valid,
    output logic              out_illegal,
    output logic              out_rec,
    output logic [OP_W-1:0]   out_op,
    output logic [FORM_W-1:0] out_form,
    output logic [REG_W-1:0]  out_rt,
    output logic [REG_W-1:0]  out_ra,
    output logic [REG_W-1:0]  out_rb,
    output logic [REG_W-1:0]  out_rc,
    output logic [CRF_W-1:0]  out_crf,
    output logic [CRF_W-1:0]  out_crs,
    output logic [IMM_W-1:0]  out_imm,
    output logic [MASK_W-1:0] out_mask
);
    logic [PRIM_W-1:0] prim;
    logic [XO_W-1:0]   xo;
    logic [AO_W-1:0]   ao;
    dec_t              mem_res, sgl_res, dbl_res, misc_res, sel;
    logic              illegal_d;
    fop_e              op_d;
    form_e             form_d;

    assign prim = insn[31:26];
    assign xo   = insn[10:1];
    assign ao   = insn[5:1];

    fpdec_mem i_mem (.prim(prim), .ra(insn[20:16]), .xo(xo), .res(mem_res));
    fpdec_arith #(.DOUBLE(1'b0)) i_sgl (.ao(ao), .res(sgl_res));
    fpdec_arith #(.DOUBLE(1'b1)) i_dbl (.ao(ao), .res(dbl_res));
    fpdec_misc i_misc (.xo(xo), .res(misc_res));

    // Picks the sub-decoder result that owns this primary opcode.
    always_comb begin
        if (prim == PRI_IDX || (prim >= PRI_MEM0 && prim <= PRI_MEM7))
            sel = mem_res;
        else if (prim == PRI_SGL)
            sel = sgl_res;
        else if (prim == PRI_DBL)
            sel = insn[5] ? dbl_res : misc_res;
        else
            sel = DEC_MISS;
    end

    // Forces the no-op encoding for any unrecognised word.
    always_comb begin
        illegal_d = !sel.hit;
        op_d      = sel.hit ? sel.op   : OP_NOP;
        form_d    = sel.hit ? sel.form : FM_NONE;
    end

    // Output stage: capture on in_valid, hold otherwise, reset clears valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_rec     <= 1'b0;
            out_op      <= OP_NOP;
            out_form    <= FM_NONE;
            out_rt      <= '0;
            out_ra      <= '0;
            out_rb      <= '0;
            out_rc      <= '0;
            out_crf     <= '0;
            out_crs     <= '0;
            out_imm     <= '0;
            out_mask    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_illegal <= illegal_d;
                out_rec     <= insn[0];
                out_op      <= op_d;
                out_form    <= form_d;
                out_rt      <= insn[25:21];
                out_ra      <= insn[20:16];
                out_rb      <= insn[15:11];
                out_rc      <= insn[10:6];
                out_crf     <= insn[25:23];
                out_crs     <= insn[20:18];
                out_imm     <= insn[15:12];
                out_mask    <= insn[24:17];
            end
        end
    end
endmodule

// File: rtl/fpdec_chk.sv
// fpdec_chk: protocol and pass-through properties of fpdec_top, bound to it.
module fpdec_chk
    import fpdec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [PRIM_W-1:0] in_prim,
    input logic [REG_W-1:0]  in_rt,
    input logic              in_rec,
    input logic              out_valid,
    input logic              out_illegal,
    input logic              out_rec,
    input logic [OP_W-1:0]   out_op,
    input logic [FORM_W-1:0] out_form,
    input logic [REG_W-1:0]  out_rt,
    input logic [MASK_W-1:0] out_mask
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_op) && $stable(out_form)
                      && $stable(out_rt) && $stable(out_mask)); // R2
    AST_LEGAL_HAS_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_illegal |-> out_form != FORM_W'(FM_NONE)); // R10
    AST_TARGET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_rt == $past(in_rt)); // R11
    AST_RECORD_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_rec == $past(in_rec)); // R13
    AST_UNKNOWN_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_prim == '0 |=> out_illegal && out_op == OP_W'(OP_NOP)); // R14
endmodule

bind fpdec_top fpdec_chk i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_prim(insn[31:26]), .in_rt(insn[25:21]), .in_rec(insn[0]),
    .out_valid(out_valid), .out_illegal(out_illegal), .out_rec(out_rec),
    .out_op(out_op), .out_form(out_form), .out_rt(out_rt), .out_mask(out_mask)
);

// File: tb/test_fpdec_top.sv
`timescale 1ns/1ps
module test_fpdec_top;
    import fpdec_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic        out_valid, out_illegal, out_rec;
    logic [5:0]  out_op;
    logic [3:0]  out_form;
    logic [4:0]  out_rt, out_ra, out_rb, out_rc;
    logic [2:0]  out_crf, out_crs;
    logic [3:0]  out_imm;
    logic [7:0]  out_mask;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    fpdec_top i_fpdec_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_rec(out_rec),
        .out_op(out_op), .out_form(out_form), .out_rt(out_rt), .out_ra(out_ra),
        .out_rb(out_rb), .out_rc(out_rc), .out_crf(out_crf), .out_crs(out_crs),
        .out_imm(out_imm), .out_mask(out_mask)
    );

    function automatic logic [31:0] w_d(int p, int rt, int ra, int disp);
        return {p[5:0], rt[4:0], ra[4:0], disp[15:0]};
    endfunction
    function automatic logic [31:0] w_x(int p, int rt, int ra, int rb, int xo, int rc);
        return {p[5:0], rt[4:0], ra[4:0], rb[4:0], xo[9:0], rc[0]};
    endfunction
    function automatic logic [31:0] w_a(int p, int rt, int ra, int rb, int rc, int ao, int rec);
        return {p[5:0], rt[4:0], ra[4:0], rb[4:0], rc[4:0], ao[4:0], rec[0]};
    endfunction

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic apply(logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        insn = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic want_ok(string req, logic [31:0] w, fop_e op, form_e fm);
        apply(w);
        chk(req, "valid", 32'(out_valid), 32'd1);
        chk(req, "illegal", 32'(out_illegal), 32'd0);
        chk(req, "op", 32'(out_op), 32'(op));
        chk(req, "form", 32'(out_form), 32'(fm));
    endtask

    task automatic want_bad(string req, logic [31:0] w);
        apply(w);
        chk(req, "illegal", 32'(out_illegal), 32'd1);
        chk(req, "op", 32'(out_op), 32'(OP_NOP));
        chk(req, "form", 32'(out_form), 32'(FM_NONE));
    endtask

    // R1: reset state while a word is offered.
    task automatic t_reset();
        in_valid = 1'b1;
        insn = w_d(50, 1, 1, 0);
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", 32'(out_valid), 32'd0);
        chk("R1", "op in reset", 32'(out_op), 32'(OP_NOP));
        chk("R1", "illegal in reset", 32'(out_illegal), 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    // R3, R4: displacement forms and the zero-base update rule.
    task automatic t_disp();
        fop_e ops[8] = '{OP_LDS, OP_LDSU, OP_LDD, OP_LDDU, OP_STS, OP_STSU, OP_STD, OP_STDU};
        for (int i = 0; i < 8; i++)
            want_ok("R3", w_d(48 + i, 3, 4, 16'h8001), ops[i], (i % 2) ? FM_DISPU : FM_DISP);
        want_ok("R3", w_d(48, 3, 0, 0), OP_LDS, FM_DISP);
        want_bad("R4", w_d(49, 3, 0, 0));
        want_bad("R4", w_d(55, 3, 0, 0));
    endtask

    // R5, R6: indexed forms under primary opcode 31.
    task automatic t_index();
        int    xos[9] = '{535, 567, 599, 631, 663, 695, 727, 759, 983};
        fop_e  ops[9] = '{OP_LDSX, OP_LDSUX, OP_LDDX, OP_LDDUX, OP_STSX, OP_STSUX,
                          OP_STDX, OP_STDUX, OP_STIW};
        for (int i = 0; i < 9; i++)
            want_ok("R5", w_x(31, 2, 5, 6, xos[i], 0), ops[i],
                    (i < 8 && i % 2 == 1) ? FM_IDXU : FM_IDX);
        want_bad("R5", w_x(31, 2, 5, 6, 536, 0));
        want_bad("R6", w_x(31, 2, 0, 6, 535, 0));
        want_bad("R6", w_x(31, 2, 0, 6, 727, 0));
        want_ok("R6", w_x(31, 2, 0, 6, 983, 0), OP_STIW, FM_IDX);
        want_ok("R6", w_x(31, 2, 0, 6, 567, 0), OP_LDSUX, FM_IDXU);
    endtask

    // R7, R8, R10: arithmetic sets of both precisions.
    task automatic t_arith();
        want_ok("R7", w_a(59, 1, 2, 3, 4, 18, 0), OP_DIVS, FM_AB);
        want_ok("R7", w_a(59, 1, 2, 3, 4, 24, 0), OP_RECS, FM_AB);
        want_ok("R7", w_a(59, 1, 2, 3, 4, 31, 0), OP_NMADDS, FM_ABC);
        want_ok("R10", w_a(59, 1, 2, 3, 4, 25, 0), OP_MULS, FM_AC);
        want_bad("R7", w_a(59, 1, 2, 3, 4, 23, 0));
        want_bad("R7", w_a(59, 1, 2, 3, 4, 26, 0));
        want_bad("R7", w_a(59, 1, 2, 3, 4, 19, 0));
        want_ok("R8", w_a(63, 1, 2, 3, 4, 23, 0), OP_SEL, FM_ABC);
        want_ok("R8", w_a(63, 1, 2, 3, 4, 26, 0), OP_RSQE, FM_AB);
        want_ok("R8", w_a(63, 1, 2, 3, 4, 21, 0), OP_ADD, FM_AB);
        want_ok("R8", w_a(63, 1, 2, 3, 4, 28, 0), OP_MSUB, FM_ABC);
        want_bad("R8", w_a(63, 1, 2, 3, 4, 24, 0));
        want_ok("R10", w_a(63, 7, 8, 9, 10, 25, 1), OP_MUL, FM_AC);
        chk("R11", "rc", 32'(out_rc), 32'd10);
        chk("R13", "rec set", 32'(out_rec), 32'd1);
    endtask

    // R9, R10: register-form set under primary opcode 63.
    task automatic t_misc();
        int    xos[15] = '{0, 12, 14, 15, 32, 38, 40, 64, 70, 72, 134, 136, 264, 583, 711};
        fop_e  ops[15] = '{OP_CMPU, OP_RND, OP_CVT, OP_CVTZ, OP_CMPO, OP_SETB, OP_NEG,
                           OP_STCR, OP_CLRB, OP_MOV, OP_SETFI, OP_NABS, OP_ABS,
                           OP_RDST, OP_WRST};
        form_e fms[15] = '{FM_CMP, FM_TB, FM_TB, FM_TB, FM_CMP, FM_BIT, FM_TB, FM_CRMOV,
                           FM_BIT, FM_TB, FM_IMM, FM_TB, FM_TB, FM_T, FM_MASK};
        for (int i = 0; i < 15; i++)
            want_ok("R9", w_x(63, 4, 5, 6, xos[i], 0), ops[i], fms[i]);
        want_bad("R9", w_x(63, 4, 5, 6, 1, 0));
        want_bad("R9", w_x(63, 4, 5, 6, 13, 0));
    endtask

    // R11, R12, R13: raw field placement.
    task automatic t_fields();
        apply(w_x(63, 5'b10110, 5'b11010, 5'b10011, 0, 1));
        chk("R11", "rt", 32'(out_rt), 32'b10110);
        chk("R11", "ra", 32'(out_ra), 32'b11010);
        chk("R11", "rb", 32'(out_rb), 32'b10011);
        chk("R12", "crf", 32'(out_crf), 32'b101);
        chk("R12", "crs", 32'(out_crs), 32'b110);
        chk("R12", "imm", 32'(out_imm), 32'b1001);
        chk("R12", "mask", 32'(out_mask), 32'h6D);
        chk("R13", "rec", 32'(out_rec), 32'd1);
    endtask

    // R14: unknown primary opcodes.
    task automatic t_unknown();
        want_bad("R14", w_d(0, 1, 2, 3));
        want_bad("R14", w_d(47, 1, 2, 3));
        want_bad("R14", w_d(56, 1, 2, 3));
        want_bad("R14", w_a(62, 1, 2, 3, 4, 21, 0));
    endtask

    // R2: hold while in_valid is low.
    task automatic t_hold();
        want_ok("R2", w_d(52, 9, 3, 0), OP_STS, FM_DISP);
        @(negedge clk);
        insn = w_d(0, 1, 1, 1);
        repeat (2) @(negedge clk);
        chk("R2", "valid low", 32'(out_valid), 32'd0);
        chk("R2", "op held", 32'(out_op), 32'(OP_STS));
        chk("R2", "illegal held", 32'(out_illegal), 32'd0);
        chk("R2", "rt held", 32'(out_rt), 32'd9);
    endtask

    initial begin
        t_reset();
        t_disp();
        t_index();
        t_arith();
        t_misc();
        t_fields();
        t_unknown();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule